// File: doc/BRIEF.md
# Software Interrupt Raise and Acknowledge Unit

This block lets any processor raise an inter-processor software interrupt on a chosen set of processors. A processor issues one 32-bit write that carries a target list and a software interrupt number. Each listed processor then holds that number as pending in its own bank. The bank keeps one flag per (target processor, interrupt number, source processor). Requests for the same number from different sources stay separate and are delivered one at a time, each with its origin attached.

A target processor reads an acknowledge value to take the next pending software interrupt in its bank. The block picks the lowest pending interrupt number. Among the sources of that number it picks the lowest source index. It returns the number and the source in the acknowledge word and clears only that one flag. When nothing is pending, the acknowledge word carries the spurious code instead. A per-processor summary output shows whether each bank holds any pending request.

Top module: `swint_gen`

## Requirements
- R1: While reset is asserted and after it is released, no bank holds a pending request: `cpu_pending` is 0 and `ack_valid` is 0.
- R2: A write (`wr_en` high) makes interrupt number `wr_data[3:0]` pending from source `wr_src` in every bank `t` whose bit `wr_data[16+t]` is 1. The matching `cpu_pending` bits are 1 on the cycle after the write. All other write bits are ignored.
- R3: A write whose target field `wr_data[23:16]` is zero changes no bank.
- R4: An acknowledge request (`ack_en` high, bank `ack_cpu`) gives `ack_valid` high for exactly the next cycle. `ack_data[9:0]` holds the interrupt number and `ack_data[12:10]` holds the source index; all other bits are 0.
- R5: Requests for one interrupt number from distinct sources to one target are kept separately, and each is acknowledged once.
- R6: When several sources are pending for the same interrupt number, the acknowledge reports the lowest source index first.
- R7: When several interrupt numbers are pending in a bank, the acknowledge reports the lowest number first.
- R8: An acknowledge of a bank with nothing pending returns `ack_data` = 1023 (0x3FF) and changes no state.
- R9: An acknowledge clears only the reported (number, source) flag in the acknowledged bank. Other sources, other numbers and other banks keep their state.
- R10: If a write sets the same flag that an acknowledge in the same cycle clears, the write wins. The acknowledge still reports that flag, and the flag stays pending.
- R11: Repeating a write that is already pending does not count. One acknowledge takes it, and the next acknowledge of that bank finds nothing from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Raise-register write strobe |
| wr_src | input | 3 | Index of the writing processor |
| wr_data | input | 32 | Write word: targets in 23:16, number in 3:0 |
| ack_en | input | 1 | Acknowledge request |
| ack_cpu | input | 3 | Bank being acknowledged |
| ack_valid | output | 1 | Acknowledge word valid |
| ack_data | output | 32 | Source in 12:10, number or 1023 in 9:0 |
| cpu_pending | output | 8 | One bit per bank: any request pending |

## Verification
Each write shows on `cpu_pending` exactly one clock after its strobe, because a bank flag register sits in between. Each acknowledge word appears with `ack_valid` on the cycle after `ack_en`, because one response register holds it. The bench drives inputs on the falling edge and compares outputs on the next falling edge, half a period after the edge that updates them. The driver pushes every expected acknowledge word into a queue at request time. A monitor pops one entry each time it sees `ack_valid`, so any shift of even one cycle shows as a mismatch or an unexpected word. A bank model in the bench checks the summary flags after every cycle, including a long pseudo-random run of mixed writes and acknowledges.

// File: rtl/swint_pkg.sv
package swint_pkg;
    // Fixed field positions of the raise word and the acknowledge word.
    localparam int TGT_LSB    = 16;
    localparam int NUM_LSB_W  = 10;
    localparam int SRC_LSB    = 10;
    localparam int SRC_FLD_W  = 3;
    localparam logic [NUM_LSB_W-1:0] SPURIOUS_ID = 10'h3FF;

    typedef struct packed {
        logic                  valid;
        logic [SRC_FLD_W-1:0]  src;
        logic [NUM_LSB_W-1:0]  num;
    } ack_rsp_t;
endpackage

// File: rtl/swint_decode.sv
module swint_decode #(
    parameter int NCPU = 8,
    parameter int NID  = 16,
    parameter int DW   = 32
) (
    input  logic                                 wr_en,
    input  logic [((NCPU > 1) ? $clog2(NCPU) : 1)-1:0] wr_src,
    input  logic [DW-1:0]                        wr_data,
    output logic [NCPU-1:0][NID-1:0][NCPU-1:0]   set_vec
);
    import swint_pkg::*;
    localparam int ID_W = (NID > 1) ? $clog2(NID) : 1;

    logic [ID_W-1:0] req_num;
    assign req_num = wr_data[ID_W-1:0];

    // One set strobe per (target bank, number, source).
    for (genvar t = 0; t < NCPU; t++) begin : g_tgt
        for (genvar i = 0; i < NID; i++) begin : g_num
            for (genvar s = 0; s < NCPU; s++) begin : g_src
                assign set_vec[t][i][s] = wr_en && wr_data[TGT_LSB+t]
                                       && (req_num == ID_W'(i))
                                       && (wr_src == $bits(wr_src)'(s));
            end
        end
    end
endmodule

// File: rtl/swint_bank.sv
module swint_bank #(
    parameter int NCPU = 8,
    parameter int NID  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NID-1:0][NCPU-1:0]   set_i,
    input  logic [NID-1:0][NCPU-1:0]   clr_i,
    output logic [NID-1:0][NCPU-1:0]   pend_o,
    output logic                       any_o
);
    typedef struct packed {
        logic [NID-1:0][NCPU-1:0] pend;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A clear is applied first so that a same-cycle set survives it.
        st_d.pend = (st_q.pend & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign any_o  = |st_q.pend;

    // A set flag is present on the next cycle even under a clear.
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // Flags neither set nor cleared keep their value.
    p_untouched_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend_o ^ $past(pend_o)) & ~($past(set_i) | $past(clr_i))) == '0));

    // A cleared flag that was not set again is gone.
    p_clear_takes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((pend_o & $past(clr_i) & ~$past(set_i)) == '0));
endmodule

// File: rtl/swint_pick.sv
module swint_pick #(
    parameter int NCPU = 8,
    parameter int NID  = 16
) (
    input  logic [NID-1:0][NCPU-1:0]   pend_i,
    output logic                       found_o,
    output logic [((NID > 1) ? $clog2(NID) : 1)-1:0]   num_o,
    output logic [((NCPU > 1) ? $clog2(NCPU) : 1)-1:0] src_o,
    output logic [NID-1:0][NCPU-1:0]   hit_o
);
    localparam int ID_W  = (NID > 1) ? $clog2(NID) : 1;
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    // Lowest number first, then lowest source within that number.
    always_comb begin
        found_o = 1'b0;
        num_o   = '0;
        src_o   = '0;
        hit_o   = '0;
        for (int i = 0; i < NID; i++) begin
            for (int s = 0; s < NCPU; s++) begin
                if (!found_o && pend_i[i][s]) begin
                    found_o     = 1'b1;
                    num_o       = ID_W'(i);
                    src_o       = CPU_W'(s);
                    hit_o[i][s] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/swint_gen.sv
module swint_gen #(
    parameter int NCPU = 8,
    parameter int NID  = 16,
    parameter int DW   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_src,
    input  logic [DW-1:0]    wr_data,
    input  logic             ack_en,
    input  logic [2:0]       ack_cpu,
    output logic             ack_valid,
    output logic [DW-1:0]    ack_data,
    output logic [NCPU-1:0]  cpu_pending
);
    import swint_pkg::*;
    localparam int ID_W  = (NID > 1) ? $clog2(NID) : 1;
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1;

    logic [NCPU-1:0][NID-1:0][NCPU-1:0] set_vec;
    logic [NCPU-1:0][NID-1:0][NCPU-1:0] clr_vec;
    logic [NCPU-1:0][NID-1:0][NCPU-1:0] bank_pend;
    logic [NID-1:0][NCPU-1:0]           sel_pend;
    logic [NID-1:0][NCPU-1:0]           sel_hit;
    logic                               pick_found;
    logic [ID_W-1:0]                    pick_num;
    logic [CPU_W-1:0]                   pick_src;
    logic                               ack_in_range;

    swint_decode #(.NCPU(NCPU), .NID(NID), .DW(DW)) u_decode (
        .wr_en   (wr_en),
        .wr_src  (CPU_W'(wr_src)),
        .wr_data (wr_data),
        .set_vec (set_vec)
    );

    for (genvar t = 0; t < NCPU; t++) begin : g_bank
        swint_bank #(.NCPU(NCPU), .NID(NID)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[t]),
            .clr_i  (clr_vec[t]),
            .pend_o (bank_pend[t]),
            .any_o  (cpu_pending[t])
        );
        assign clr_vec[t] = (ack_en && ack_in_range && (CPU_W'(ack_cpu) == CPU_W'(t)))
                          ? sel_hit : '0;
    end

    assign ack_in_range = (32'(ack_cpu) < NCPU);
    assign sel_pend     = ack_in_range ? bank_pend[CPU_W'(ack_cpu)] : '0;

    swint_pick #(.NCPU(NCPU), .NID(NID)) u_pick (
        .pend_i  (sel_pend),
        .found_o (pick_found),
        .num_o   (pick_num),
        .src_o   (pick_src),
        .hit_o   (sel_hit)
    );

    ack_rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = ack_en;
        if (ack_en) begin
            if (pick_found) begin
                rsp_d.src = SRC_FLD_W'(pick_src);
                rsp_d.num = NUM_LSB_W'(pick_num);
            end else begin
                rsp_d.src = '0;
                rsp_d.num = SPURIOUS_ID;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign ack_valid = rsp_q.valid;
    assign ack_data  = DW'({rsp_q.src, rsp_q.num});

    // Response is a one-cycle echo of the request.
    p_ack_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_en |=> ack_valid);
    p_ack_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_en |=> !ack_valid);

    // Empty bank answers with the spurious code.
    p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_en && ack_in_range && !cpu_pending[CPU_W'(ack_cpu)])
        |=> (ack_data == DW'(SPURIOUS_ID)));

    // An empty target list leaves every bank as it was (absent acknowledges).
    p_empty_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_data[TGT_LSB+7:TGT_LSB] == 8'h00) && !ack_en)
        |=> $stable(cpu_pending));

    // The reported flag is one the selected bank really holds.
    p_pick_real_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pick_found |-> sel_pend[pick_num][pick_src]);

    // Nothing pends straight out of reset.
    p_reset_clean_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (cpu_pending == '0 && !ack_valid));
endmodule

// File: tb/sim_swint_gen.sv
module sim_swint_gen;
    localparam int NCPU = 8;
    localparam int NID  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_src = '0;
    logic [31:0] wr_data = '0;
    logic        ack_en = 1'b0;
    logic [2:0]  ack_cpu = '0;
    logic        ack_valid;
    logic [31:0] ack_data;
    logic [7:0]  cpu_pending;

    always #4 clk = ~clk;   // 125 MHz

    swint_gen u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_src(wr_src),
        .wr_data(wr_data), .ack_en(ack_en), .ack_cpu(ack_cpu),
        .ack_valid(ack_valid), .ack_data(ack_data), .cpu_pending(cpu_pending)
    );

    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   model [NCPU][NID][NCPU];
    bit   done = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_any();
        logic [7:0] r = '0;
        for (int t = 0; t < NCPU; t++)
            for (int i = 0; i < NID; i++)
                for (int s = 0; s < NCPU; s++)
                    if (model[t][i][s]) r[t] = 1'b1;
        return r;
    endfunction

    // Driver: one cycle of optional write and optional acknowledge.
    task automatic step(input bit w, input logic [2:0] src, input logic [31:0] data,
                        input bit a, input logic [2:0] cpu, input string tag);
        exp_t e;
        bit   hit;
        hit = 1'b0;
        e.tag  = tag;
        e.data = 32'h3FF;
        if (a) begin
            for (int i = 0; i < NID; i++)
                for (int s = 0; s < NCPU; s++)
                    if (!hit && model[cpu][i][s]) begin
                        hit = 1'b1;
                        e.data = (32'(s) << 10) | 32'(i);
                        model[cpu][i][s] = 1'b0;
                    end
            exp_q.push_back(e);
        end
        if (w)
            for (int t = 0; t < NCPU; t++)
                if (data[16+t]) model[t][data[3:0]][src] = 1'b1;
        wr_en = w; wr_src = src; wr_data = data;
        ack_en = a; ack_cpu = cpu;
        @(negedge clk);
        wr_en = 1'b0; ack_en = 1'b0;
        check(cpu_pending == model_any(), {tag, " R2 R9 pending"},
              32'(cpu_pending), 32'(model_any()));
    endtask

    task automatic wr(input logic [2:0] src, input logic [31:0] data, input string tag);
        step(1'b1, src, data, 1'b0, 3'd0, tag);
    endtask

    task automatic ack(input logic [2:0] cpu, input string tag);
        step(1'b0, 3'd0, 32'd0, 1'b1, cpu, tag);
    endtask

    // Monitor: compare each produced acknowledge word against the queue.
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected ack", ack_data, 32'hx);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(ack_data === e.data, {e.tag, " ack word"}, ack_data, e.data);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            check(1'b0, "watchdog expired", 32'(cyc), 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int t = 0; t < NCPU; t++)
            for (int i = 0; i < NID; i++)
                for (int s = 0; s < NCPU; s++) model[t][i][s] = 1'b0;
        repeat (3) @(negedge clk);
        check(cpu_pending == 0, "R1 pending in reset", 32'(cpu_pending), 0);
        check(ack_valid == 0, "R1 ack_valid in reset", 32'(ack_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_pending == 0 && ack_valid == 0, "R1 after release",
              {23'd0, ack_valid, cpu_pending}, 0);

        ack(3'd0, "R8 empty bank");
        wr(3'd2, 32'h0005_0005, "R2 two targets");
        wr(3'd1, 32'hFF03_DFF7, "R2 junk bits ignored");
        wr(3'd5, 32'h0000_FFF3, "R3 empty targets");
        wr(3'd0, 32'h0001_0005, "R5 src0");
        wr(3'd6, 32'h0001_0005, "R5 src6");
        ack(3'd0, "R6 lowest source");
        ack(3'd0, "R5 second source");
        ack(3'd0, "R5 third source");
        ack(3'd0, "R7 next number");
        ack(3'd0, "R8 drained");
        check(cpu_pending[2] && cpu_pending[1], "R9 other banks kept",
              32'(cpu_pending), 32'h6);
        ack(3'd1, "R7 bank1");
        ack(3'd2, "R9 bank2");
        ack(3'd2, "R9 bank2 empty");
        wr(3'd4, 32'h0080_000C, "R11 first");
        wr(3'd4, 32'h0080_000C, "R11 repeat");
        ack(3'd7, "R11 one take");
        ack(3'd7, "R11 no second");
        wr(3'd4, 32'h0008_0009, "R10 prime");
        step(1'b1, 3'd4, 32'h0008_0009, 1'b1, 3'd3, "R10 collide");
        ack(3'd3, "R10 survives");
        ack(3'd3, "R10 then empty");

        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            logic [31:0] d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d = {8'h00, lfsr[15:8] & {8{lfsr[1]}}, 4'h0, lfsr[7:4]};
            step(lfsr[0], lfsr[3:1], d, lfsr[2] | lfsr[5], lfsr[11:9], "R6 R7 mixed run");
        end
        for (int t = 0; t < NCPU; t++)
            for (int n = 0; n < NID * NCPU + 1; n++) ack(3'(t), "R7 drain");
        @(negedge clk);
        check(exp_q.size() == 0, "R4 missing acks", 32'(exp_q.size()), 0);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule